// File: doc/BRIEF.md
# Spindle Mode Sequencer with Brake Delay

This block decides which operating mode the three-phase spindle drive is in. It steps between a tristate idle mode, start, run, a brake-delay coast, brake, a fault tristate and a thermal tristate. The inputs are control-register bits, fault flags, a flag that says the commutation preload pattern is all ones, the spindle commutation clock, and a strobe for each negative zero crossing of phase A.

From the current mode the block drives plain mode lines to the rest of the spindle logic. These lines select slew control, the start current limit, three-phase or single-phase back-EMF sensing, the drive source (commutation counter or preload pattern), tristate and all-low-side braking. It also drives three status bits that mark the park period and the brake action.

Every mode change waits for a rising edge of the spindle clock. The coast before braking is measured in motor back-EMF events rather than in clock cycles, so the time the actuator has to retract follows the spin-down speed of the motor.

Top module: `spindle_mode_seq`

## Requirements
- R1: The mode changes only in a clk cycle in which `spin_clk` is high and was low in the previous cycle. Without such an edge the mode holds, whatever the other inputs do.
- R2: After `rst_n` is released, `mode` reads 0 (idle tristate). In that state `drv_tristate`=1, `bemf_3ph`=1, and `slew_en`, `ilim_en`, `drv_from_cnt`, `drv_brake` and all three status bits are 0.
- R3: The idle tristate mode (0) moves to start (1) on a spindle edge only when all of these hold. Since the mode was last entered, there has been a `start_wr` strobe with `reg_start`=1 and a `pre_wr` strobe, and `sp_en` has been seen low and then high. Also, `reg_start` must still be 1. If any of these is missing, the block stays in mode 0.
- R4: In start mode (1): `slew_en`=0, `ilim_en`=1, `bemf_3ph`=1, `drv_from_cnt`=0, `drv_tristate`=0.
- R5: Start moves to run (2) on a spindle edge while `pre_ones`=1. Run moves back to start on a spindle edge while `pre_ones`=0. In run mode: `slew_en`=1, `ilim_en`=0, `bemf_3ph`=0, `drv_from_cnt`=1.
- R6: The block enters brake delay (3) on a spindle edge in either of two cases: `brake_req`=1 while in start or run; or `por_flt` or `uv_flt` is high while in mode 0, 1, 2 or 5. In brake delay: `drv_tristate`=1 and `st_park_start`=1.
- R7: Brake delay counts `zc_a_fall` strobes. After the 128th strobe `st_park_end` becomes 1, and the next spindle edge moves the mode to brake (4). After only 127 strobes the mode stays 3 and `st_park_end` stays 0.
- R8: In brake mode: `drv_brake`=1 (all low-side drivers on), `drv_tristate`=0, `ilim_en`=0, and all three status bits are 1. Brake moves to mode 0 on a spindle edge once `brake_req`, `por_flt` and `uv_flt` are all 0.
- R9: The strobe count clears whenever the mode leaves brake delay, so a new brake delay again needs a full 128 strobes.
- R10: `therm_shut`=1 on a spindle edge moves any mode to thermal tristate (6). This takes priority over every other condition. Mode 6 returns to mode 0 on a spindle edge with `therm_shut`=0, and `drv_tristate`=1 while in mode 6.
- R11: `therm_warn`=1 on a spindle edge in start or run (with no brake request) moves the mode to fault tristate (5), with `drv_tristate`=1. Mode 5 returns to mode 0 on a spindle edge with `therm_warn`=0.
- R12: `sp_en`=0 on a spindle edge in start or run (with no brake request or warning) returns the mode to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_start | input | 1 | Start control bit |
| start_wr | input | 1 | Strobe: start bit was written |
| pre_wr | input | 1 | Strobe: preload pattern was written |
| pre_ones | input | 1 | Preload pattern is all ones |
| sp_en | input | 1 | Spindle enable bit |
| brake_req | input | 1 | Register brake request |
| por_flt | input | 1 | Power-on-reset fault |
| uv_flt | input | 1 | Undervoltage fault |
| therm_shut | input | 1 | Thermal shutdown |
| therm_warn | input | 1 | Thermal warning |
| spin_clk | input | 1 | Spindle commutation clock (level, sampled on clk) |
| zc_a_fall | input | 1 | One-cycle strobe per phase-A negative zero crossing |
| mode | output | 3 | Mode code: 0 idle Z, 1 start, 2 run, 3 brake delay, 4 brake, 5 fault Z, 6 thermal Z |
| slew_en | output | 1 | Output slew control on |
| ilim_en | output | 1 | Start current limit on |
| bemf_3ph | output | 1 | 1: sense all three phases; 0: phase A only |
| drv_from_cnt | output | 1 | 1: drive from commutation counter; 0: from preload |
| drv_tristate | output | 1 | All spindle drivers off |
| drv_brake | output | 1 | All low-side drivers on |
| st_park_start | output | 1 | Park period has started |
| st_park_end | output | 1 | Park period has ended |
| st_brake_start | output | 1 | Brake action has started |

## Verification
The hardest situation to reach is the count clearing when the mode leaves brake delay part way through. To build it, the stimulus enters brake delay, applies 100 phase-A strobes, and forces a thermal exit. It then rearms the sequencer through the full idle-exit ritual and enters brake delay again. After 100 more strobes, `st_park_end` must still be 0: a count that failed to clear would already have passed 128. The 127-versus-128 boundary and the rule that nothing moves without a spindle edge are each checked by holding inputs across many clk cycles with no edge.

// File: rtl/spm_pkg.sv
`timescale 1ns/1ps
package spm_pkg;

  typedef enum logic [2:0] {
    SM_Z     = 3'd0,
    SM_START = 3'd1,
    SM_RUN   = 3'd2,
    SM_BDLY  = 3'd3,
    SM_BRAKE = 3'd4,
    SM_FTRI  = 3'd5,
    SM_THERM = 3'd6
  } spm_mode_e;

  typedef struct packed {
    logic slew;
    logic ilim;
    logic bemf3;
    logic from_cnt;
    logic tri_st;
    logic brake;
    logic park_start;
    logic park_end;
    logic brake_start;
  } spm_ctl_t;

endpackage

// File: rtl/spm_edge.sv
`timescale 1ns/1ps
module spm_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic spin_clk,
  output logic spin_rise
);
  logic spin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) spin_q <= 1'b0;
    else        spin_q <= spin_clk;
  end

  assign spin_rise = spin_clk & ~spin_q;

  // one event per spindle edge, never two cycles in a row
  assert_edge_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    spin_rise |=> !spin_rise);
endmodule

// File: rtl/spm_arm.sv
`timescale 1ns/1ps
module spm_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic reg_start,
  input  logic start_wr,
  input  logic pre_wr,
  input  logic sp_en,
  output logic armed
);
  logic start_seen, pre_seen, en_low_seen, en_pulsed;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      start_seen  <= 1'b0;
      pre_seen    <= 1'b0;
      en_low_seen <= 1'b0;
      en_pulsed   <= 1'b0;
    end else begin
      if (start_wr && reg_start) start_seen <= 1'b1;
      if (pre_wr)                pre_seen   <= 1'b1;
      if (!sp_en)                en_low_seen <= 1'b1;
      if (en_low_seen && sp_en)  en_pulsed  <= 1'b1;
    end
  end

  assign armed = start_seen & pre_seen & en_pulsed & reg_start;

  // clearing on entry to idle drops the arm conditions
  assert_clear_disarms_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !armed);
endmodule

// File: rtl/spm_bdly.sv
`timescale 1ns/1ps
module spm_bdly #(
  parameter int CNT_W = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_bd,
  input  logic zc,
  output logic done
);
  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !in_bd) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (zc && !done) begin
      if (cnt == LAST) done <= 1'b1;
      else             cnt  <= cnt + 1'b1;
    end
  end

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bd && zc && !done && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1 || !$past(in_bd)));

  assert_clear_on_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_bd |=> (cnt == '0 && !done));
endmodule

// File: rtl/spm_fsm.sv
`timescale 1ns/1ps
module spm_fsm
  import spm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      spin_rise,
  input  logic      armed,
  input  logic      bd_done,
  input  logic      pre_ones,
  input  logic      sp_en,
  input  logic      brake_req,
  input  logic      por_flt,
  input  logic      uv_flt,
  input  logic      therm_shut,
  input  logic      therm_warn,
  output spm_mode_e st,
  output logic      z_clear
);
  spm_mode_e nxt;
  logic      pwr_flt;

  assign pwr_flt = por_flt | uv_flt;

  always_comb begin
    nxt = st;
    if (spin_rise) begin
      if (therm_shut) begin
        nxt = SM_THERM;
      end else if (pwr_flt && st != SM_BDLY && st != SM_BRAKE && st != SM_THERM) begin
        nxt = SM_BDLY;
      end else begin
        case (st)
          SM_Z:     if (armed) nxt = SM_START;
          SM_START: begin
            if (brake_req)       nxt = SM_BDLY;
            else if (therm_warn) nxt = SM_FTRI;
            else if (!sp_en)     nxt = SM_Z;
            else if (pre_ones)   nxt = SM_RUN;
          end
          SM_RUN: begin
            if (brake_req)       nxt = SM_BDLY;
            else if (therm_warn) nxt = SM_FTRI;
            else if (!sp_en)     nxt = SM_Z;
            else if (!pre_ones)  nxt = SM_START;
          end
          SM_BDLY:  if (bd_done) nxt = SM_BRAKE;
          SM_BRAKE: if (!brake_req && !pwr_flt) nxt = SM_Z;
          SM_FTRI:  if (!therm_warn) nxt = SM_Z;
          SM_THERM: nxt = SM_Z;
          default:  nxt = SM_Z;
        endcase
      end
    end
  end

  assign z_clear = spin_rise && (nxt == SM_Z) && (st != SM_Z);

  always_ff @(posedge clk) begin
    if (!rst_n) st <= SM_Z;
    else        st <= nxt;
  end

  assert_hold_without_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !spin_rise |=> $stable(st));

  assert_brake_after_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SM_BRAKE && $past(st) == SM_BDLY) |-> $past(bd_done));

  assert_thermal_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (spin_rise && therm_shut) |=> st == SM_THERM);

  assert_pwr_fault_brakes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (spin_rise && !therm_shut && pwr_flt && (st == SM_Z || st == SM_START || st == SM_RUN))
      |=> st == SM_BDLY);

  assert_idle_exit_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SM_START && $past(st) == SM_Z) |-> $past(armed));
endmodule

// File: rtl/spm_dec.sv
`timescale 1ns/1ps
module spm_dec
  import spm_pkg::*;
(
  input  spm_mode_e st,
  input  logic      bd_done,
  output spm_ctl_t  ctl
);
  always_comb begin
    ctl       = '0;
    ctl.bemf3 = 1'b1;
    case (st)
      SM_Z:     ctl.tri_st = 1'b1;
      SM_START: ctl.ilim   = 1'b1;
      SM_RUN: begin
        ctl.slew     = 1'b1;
        ctl.bemf3    = 1'b0;
        ctl.from_cnt = 1'b1;
      end
      SM_BDLY: begin
        ctl.tri_st     = 1'b1;
        ctl.bemf3      = 1'b0;
        ctl.park_start = 1'b1;
        ctl.park_end   = bd_done;
      end
      SM_BRAKE: begin
        ctl.brake       = 1'b1;
        ctl.park_start  = 1'b1;
        ctl.park_end    = 1'b1;
        ctl.brake_start = 1'b1;
      end
      default:  ctl.tri_st = 1'b1;
    endcase
  end

  always_comb begin
    assert_drv_exclusive_R8: assert (!(ctl.tri_st && ctl.brake));
    assert_slew_vs_limit_R5: assert (!(ctl.slew && ctl.ilim));
  end
endmodule

// File: rtl/spindle_mode_seq.sv
`timescale 1ns/1ps
module spindle_mode_seq
  import spm_pkg::*;
#(
  parameter int DLY_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_start,
  input  logic       start_wr,
  input  logic       pre_wr,
  input  logic       pre_ones,
  input  logic       sp_en,
  input  logic       brake_req,
  input  logic       por_flt,
  input  logic       uv_flt,
  input  logic       therm_shut,
  input  logic       therm_warn,
  input  logic       spin_clk,
  input  logic       zc_a_fall,
  output logic [2:0] mode,
  output logic       slew_en,
  output logic       ilim_en,
  output logic       bemf_3ph,
  output logic       drv_from_cnt,
  output logic       drv_tristate,
  output logic       drv_brake,
  output logic       st_park_start,
  output logic       st_park_end,
  output logic       st_brake_start
);
  logic      spin_rise, armed, z_clear, bd_done;
  spm_mode_e st;
  spm_ctl_t  ctl;

  spm_edge u_edge (
    .clk(clk), .rst_n(rst_n), .spin_clk(spin_clk), .spin_rise(spin_rise)
  );

  spm_arm u_arm (
    .clk(clk), .rst_n(rst_n), .clr(z_clear), .reg_start(reg_start),
    .start_wr(start_wr), .pre_wr(pre_wr), .sp_en(sp_en), .armed(armed)
  );

  spm_bdly #(.CNT_W(DLY_W)) u_bdly (
    .clk(clk), .rst_n(rst_n), .in_bd(st == SM_BDLY), .zc(zc_a_fall), .done(bd_done)
  );

  spm_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .spin_rise(spin_rise), .armed(armed),
    .bd_done(bd_done), .pre_ones(pre_ones), .sp_en(sp_en),
    .brake_req(brake_req), .por_flt(por_flt), .uv_flt(uv_flt),
    .therm_shut(therm_shut), .therm_warn(therm_warn),
    .st(st), .z_clear(z_clear)
  );

  spm_dec u_dec (.st(st), .bd_done(bd_done), .ctl(ctl));

  assign mode           = st;
  assign slew_en        = ctl.slew;
  assign ilim_en        = ctl.ilim;
  assign bemf_3ph       = ctl.bemf3;
  assign drv_from_cnt   = ctl.from_cnt;
  assign drv_tristate   = ctl.tri_st;
  assign drv_brake      = ctl.brake;
  assign st_park_start  = ctl.park_start;
  assign st_park_end    = ctl.park_end;
  assign st_brake_start = ctl.brake_start;
endmodule

// File: tb/tb_spindle_mode_seq.sv
`timescale 1ns/1ps
module tb_spindle_mode_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_start = 0, start_wr = 0, pre_wr = 0, pre_ones = 0, sp_en = 0;
  logic brake_req = 0, por_flt = 0, uv_flt = 0, therm_shut = 0, therm_warn = 0;
  logic spin_clk = 0, zc_a_fall = 0;
  logic [2:0] mode;
  logic slew_en, ilim_en, bemf_3ph, drv_from_cnt, drv_tristate, drv_brake;
  logic st_park_start, st_park_end, st_brake_start;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spindle_mode_seq dut (
    .clk(clk), .rst_n(rst_n), .reg_start(reg_start), .start_wr(start_wr),
    .pre_wr(pre_wr), .pre_ones(pre_ones), .sp_en(sp_en), .brake_req(brake_req),
    .por_flt(por_flt), .uv_flt(uv_flt), .therm_shut(therm_shut),
    .therm_warn(therm_warn), .spin_clk(spin_clk), .zc_a_fall(zc_a_fall),
    .mode(mode), .slew_en(slew_en), .ilim_en(ilim_en), .bemf_3ph(bemf_3ph),
    .drv_from_cnt(drv_from_cnt), .drv_tristate(drv_tristate), .drv_brake(drv_brake),
    .st_park_start(st_park_start), .st_park_end(st_park_end),
    .st_brake_start(st_brake_start)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spin();
    @(negedge clk) spin_clk = 1'b1;
    @(negedge clk) spin_clk = 1'b0;
  endtask

  task automatic zc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) zc_a_fall = 1'b1;
      @(negedge clk) zc_a_fall = 1'b0;
    end
  endtask

  task automatic arm_to_start();
    pre_ones = 0; sp_en = 0; reg_start = 1;
    idle(2);
    start_wr = 1; @(negedge clk) start_wr = 0;
    pre_wr = 1;   @(negedge clk) pre_wr = 0;
    sp_en = 1;    idle(2);
    spin();
  endtask

  task automatic t_reset();
    chk("R2 mode", mode, 0);
    chk("R2 tristate", drv_tristate, 1);
    chk("R2 bemf3", bemf_3ph, 1);
    chk("R2 slew/ilim/cnt/brake", {slew_en, ilim_en, drv_from_cnt, drv_brake}, 0);
    chk("R2 status", {st_park_start, st_park_end, st_brake_start}, 0);
  endtask

  task automatic t_idle_exit();
    reg_start = 1;
    start_wr = 1; @(negedge clk) start_wr = 0;
    pre_wr = 1;   @(negedge clk) pre_wr = 0;
    spin();
    chk("R3 no enable pulse stays idle", mode, 0);
    sp_en = 1; idle(20);
    chk("R1 armed but no edge", mode, 0);
    spin();
    chk("R3 armed edge enters start", mode, 1);
    chk("R4 start slew", slew_en, 0);
    chk("R4 start ilim", ilim_en, 1);
    chk("R4 start bemf3", bemf_3ph, 1);
    chk("R4 start from_cnt", drv_from_cnt, 0);
    chk("R4 start tristate", drv_tristate, 0);
  endtask

  task automatic t_start_run();
    pre_ones = 1; idle(15);
    chk("R1 start holds without edge", mode, 1);
    spin();
    chk("R5 run entered", mode, 2);
    chk("R5 run outputs", {slew_en, ilim_en, bemf_3ph, drv_from_cnt}, 4'b1001);
    pre_ones = 0; spin();
    chk("R5 back to start", mode, 1);
    pre_ones = 1; spin();
    chk("R5 run again", mode, 2);
  endtask

  task automatic t_brake();
    brake_req = 1; spin();
    chk("R6 brake delay entered", mode, 3);
    chk("R6 tristate", drv_tristate, 1);
    chk("R6 park start", st_park_start, 1);
    zc(127); spin();
    chk("R7 127 strobes stays", mode, 3);
    chk("R7 127 park end", st_park_end, 0);
    zc(1);
    chk("R7 128 park end", st_park_end, 1);
    chk("R1 done waits edge", mode, 3);
    spin();
    chk("R7 brake entered", mode, 4);
    chk("R8 low sides", drv_brake, 1);
    chk("R8 no tristate", drv_tristate, 0);
    chk("R8 ilim off", ilim_en, 0);
    chk("R8 status", {st_park_start, st_park_end, st_brake_start}, 3'b111);
    spin();
    chk("R8 holds with request", mode, 4);
    brake_req = 0; spin();
    chk("R8 exit to idle", mode, 0);
  endtask

  task automatic t_clear();
    arm_to_start();
    chk("R3 rearm start", mode, 1);
    brake_req = 1; spin();
    chk("R6 bd again", mode, 3);
    zc(100);
    therm_shut = 1; spin();
    chk("R10 thermal from bd", mode, 6);
    chk("R10 tristate", drv_tristate, 1);
    brake_req = 0; therm_shut = 0; spin();
    chk("R10 exit to idle", mode, 0);
    arm_to_start();
    brake_req = 1; spin();
    chk("R9 bd reentered", mode, 3);
    zc(100); spin();
    chk("R9 count cleared mode", mode, 3);
    chk("R9 count cleared park end", st_park_end, 0);
    zc(28); spin();
    chk("R9 full count reaches brake", mode, 4);
    brake_req = 0; spin();
    chk("R8 idle again", mode, 0);
  endtask

  task automatic t_power_fault();
    sp_en = 0;
    uv_flt = 1; spin();
    chk("R6 uv from idle", mode, 3);
    zc(128); spin();
    chk("R7 uv brake", mode, 4);
    uv_flt = 0; por_flt = 1; spin();
    chk("R8 por holds brake", mode, 4);
    por_flt = 0; spin();
    chk("R8 released", mode, 0);
  endtask

  task automatic t_warn();
    arm_to_start();
    pre_ones = 1; spin();
    chk("R5 run for warn", mode, 2);
    therm_warn = 1; spin();
    chk("R11 fault tristate", mode, 5);
    chk("R11 tristate", drv_tristate, 1);
    spin();
    chk("R11 holds while warn", mode, 5);
    therm_warn = 0; spin();
    chk("R11 exit idle", mode, 0);
  endtask

  task automatic t_enable_and_priority();
    arm_to_start();
    sp_en = 0; spin();
    chk("R12 enable low to idle", mode, 0);
    arm_to_start();
    brake_req = 1; therm_shut = 1; spin();
    chk("R10 thermal beats brake", mode, 6);
    brake_req = 0; therm_shut = 0; spin();
    chk("R10 back idle", mode, 0);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_idle_exit();
    t_start_run();
    t_brake();
    t_clear();
    t_power_fault();
    t_warn();
    t_enable_and_priority();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule